// File: doc/BRIEF.md
# Transmit Byte Queue with Abort Flush

This block is a twelve-entry circular byte queue placed between a processor and a serial shifter. The processor pushes bytes through a write port. The shifter takes them from the head through a strobe that consumes one byte per pulse. Each side has its own index, and each index only moves forward, stepping from the last slot back to slot zero. Full and empty are registered flags. They change only when an access or a flush event takes place.

A processor read does not return the head of the queue. It returns the slot the next processor write would fill, and the write index does not move. When the chip-select is released before the last queued byte has gone out, the shifter raises an abort input. The abort returns both indices to zero, marks the queue empty and sets a sticky flush indicator, which stays set until the processor clears it. A low-power flush input has the same effect and is used when the chip enters a sleep state.

Top module: `tx_byte_queue`

## Requirements
- R1: The queue holds 12 bytes. Bytes reach `ser_data` in the order they were written, including when the indices step from slot 11 back to slot 0.
- R2: A processor write (`cpu_wr`=1) stores `cpu_wdata` at the write index and then advances the index. A write while `full`=1 is ignored: the stored data, the index and `cpu_rdata` do not change.
- R3: `cpu_rdata` always shows the byte held at the current write index. Reading it moves no index. After reset every slot reads 0.
- R4: `ser_data` shows the byte at the read index. A pulse on `ser_rd` advances the read index by one slot. A pulse on `ser_rd` while `empty`=1 is ignored.
- R5: `full` becomes 1 when an accepted write leaves the two indices equal. Any accepted serial read clears `full`.
- R6: After an accepted serial read, `empty` becomes 1 exactly when the indices are equal. An accepted write with no read in the same cycle clears `empty`.
- R7: A cycle with `abort`=1 sets both indices to 0 and gives `empty`=1, `full`=0 and `flush_flag`=1 on the next cycle. Any write or read in that same cycle is discarded.
- R8: A cycle with `lp_flush`=1 has the same effect as `abort`.
- R9: After reset, `empty`=1, `full`=0 and `flush_flag`=1.
- R10: `flush_flag` stays 1 until a cycle with `flush_clr`=1. If a flush event arrives in the same cycle as `flush_clr`, the flag stays set.
- R11: If a write and a serial read are both accepted in the same cycle, both take effect. The flags are then computed from the updated indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Byte at the current write index (peek) |
| ser_rd | input | 1 | Shifter consume strobe |
| ser_data | output | 8 | Byte at the current read index |
| abort | input | 1 | Early chip-select release from the shifter |
| lp_flush | input | 1 | Flush request on entry to low power |
| flush_clr | input | 1 | Clears the flush indicator |
| full | output | 1 | Queue full flag |
| empty | output | 1 | Queue empty flag |
| flush_flag | output | 1 | Sticky flush indicator |

## Verification
The bench builds the block with its default parameters: 12 slots of 8 bits each. With only twelve slots, one fill-and-drain pass that starts at slot 3 pushes both indices across the step from slot 11 to slot 0. That pass also reaches the full state, where the peeked write slot coincides with the oldest byte. Short directed sequences cover the remaining cases. These are a read with a simultaneous write, a read while empty, and a flush that coincides with both an access and a flag clear.

// File: rtl/txq_pkg.sv
// Shared types and helpers for the transmit byte queue.
// Assumes the depth fits in an int and is at least 2.
package txq_pkg;

    // Registered status of the queue
    typedef struct packed {
        logic full;
        logic empty;
        logic flushed;
    } txq_flags_t;

    // Next slot after p in a ring of the given depth
    function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/txq_wrap_ptr.sv
// Forward-only ring index. It steps on inc, returns to zero on clr, and wraps
// at DEPTH-1. It also exposes its next value so that flags can be formed from
// the updated index. Assumes clr wins over inc.
module txq_wrap_ptr #(
    parameter int DEPTH = 12,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] ptr_nxt
);
    import txq_pkg::*;

    // Choose the index value for the next cycle
    always_comb begin
        if (clr)
            ptr_nxt = '0;
        else if (inc)
            ptr_nxt = PW'(ring_next(int'(ptr), DEPTH));
        else
            ptr_nxt = ptr;
    end

    // Hold the index
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else
            ptr <= ptr_nxt;
    end
endmodule

// File: rtl/txq_store.sv
// Byte storage with one write port and two asynchronous read ports.
// Reset clears every slot so that peeks are defined. A flush does not
// touch the contents.
module txq_store #(
    parameter int DEPTH = 12,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr_a,
    input  logic [PW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] slot [DEPTH];

    // Clear on reset, otherwise store on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= '0;
        end else if (we) begin
            slot[waddr] <= wdata;
        end
    end

    // Two read taps
    assign rdata_a = slot[raddr_a];
    assign rdata_b = slot[raddr_b];
endmodule

// File: rtl/txq_flags.sv
// Event-driven status flags. Full and empty change only on accepted accesses
// or on a flush, and are formed from the updated indices. The flush indicator
// is sticky, and a new flush takes priority over a clear.
module txq_flags #(
    parameter int DEPTH = 12,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_evt,
    input  logic                flush_clr,
    input  logic                wr_ok,
    input  logic                rd_ok,
    input  logic [PW-1:0]       wp_nxt,
    input  logic [PW-1:0]       rp_nxt,
    output txq_pkg::txq_flags_t flags
);
    logic same_nxt;

    // Index equality after this cycle's update
    assign same_nxt = (wp_nxt == rp_nxt);

    // Update the flags on events only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.full    <= 1'b0;
            flags.empty   <= 1'b1;
            flags.flushed <= 1'b1;
        end else begin
            if (flush_evt) begin
                flags.full  <= 1'b0;
                flags.empty <= 1'b1;
            end else if (rd_ok) begin
                flags.full  <= 1'b0;
                flags.empty <= same_nxt;
            end else if (wr_ok) begin
                flags.full  <= same_nxt;
                flags.empty <= 1'b0;
            end

            if (flush_evt)
                flags.flushed <= 1'b1;
            else if (flush_clr)
                flags.flushed <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_byte_queue.sv
// Transmit byte queue. The processor fills it and the serial shifter drains
// it. A processor read peeks at the write slot. An abort or a low-power flush
// zeroes both indices and raises a sticky flush indicator. Assumes the shifter
// asserts abort only for a chip-select release before the last bit of the last
// queued byte. Writes while full and reads while empty are dropped.
module tx_byte_queue #(
    parameter int DEPTH = 12,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [WIDTH-1:0] cpu_wdata,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic             ser_rd,
    output logic [WIDTH-1:0] ser_data,
    input  logic             abort,
    input  logic             lp_flush,
    input  logic             flush_clr,
    output logic             full,
    output logic             empty,
    output logic             flush_flag
);
    import txq_pkg::*;

    txq_flags_t    flags;
    logic          flush_evt;
    logic          wr_ok;
    logic          rd_ok;
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [PW-1:0] wp_nxt;
    logic [PW-1:0] rp_nxt;

    // Accept accesses only when the flags allow them and no flush is pending
    assign flush_evt = abort | lp_flush;
    assign wr_ok     = cpu_wr & ~flags.full  & ~flush_evt;
    assign rd_ok     = ser_rd & ~flags.empty & ~flush_evt;

    txq_wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(flush_evt), .inc(wr_ok),
        .ptr(wp), .ptr_nxt(wp_nxt)
    );

    txq_wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(flush_evt), .inc(rd_ok),
        .ptr(rp), .ptr_nxt(rp_nxt)
    );

    txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wp), .wdata(cpu_wdata),
        .raddr_a(wp), .raddr_b(rp), .rdata_a(cpu_rdata), .rdata_b(ser_data)
    );

    txq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .flush_evt(flush_evt), .flush_clr(flush_clr),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wp_nxt(wp_nxt), .rp_nxt(rp_nxt),
        .flags(flags)
    );

    // Drive the status outputs
    assign full       = flags.full;
    assign empty      = flags.empty;
    assign flush_flag = flags.flushed;
endmodule

// File: rtl/txq_chk.sv
// Port-level checker for the transmit byte queue, bound to every instance.
module txq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr,
    input logic             ser_rd,
    input logic             abort,
    input logic             lp_flush,
    input logic             flush_clr,
    input logic [WIDTH-1:0] cpu_rdata,
    input logic [WIDTH-1:0] ser_data,
    input logic             full,
    input logic             empty,
    input logic             flush_flag
);
    // R5 R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7
    abort_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (empty && !full && flush_flag));

    // R8
    lp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_flush |=> (empty && !full && flush_flag));

    // R2
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cpu_wr && !ser_rd && !abort && !lp_flush) |=> (full && $stable(cpu_rdata)));

    // R4
    empty_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && ser_rd && !cpu_wr && !abort && !lp_flush) |=> (empty && $stable(ser_data)));

    // R10
    flush_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_flag && !flush_clr) |=> flush_flag);
endmodule

bind tx_byte_queue txq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .ser_rd(ser_rd), .abort(abort),
    .lp_flush(lp_flush), .flush_clr(flush_clr), .cpu_rdata(cpu_rdata),
    .ser_data(ser_data), .full(full), .empty(empty), .flush_flag(flush_flag)
);

// File: tb/sim_tx_byte_queue.sv
`timescale 1ns/1ps
// Directed bench for the transmit byte queue: one task per scenario.
// Inputs change on falling edges, and outputs are sampled on falling edges.
module sim_tx_byte_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       ser_rd = 1'b0;
    logic [7:0] ser_data;
    logic       abort = 1'b0;
    logic       lp_flush = 1'b0;
    logic       flush_clr = 1'b0;
    logic       full;
    logic       empty;
    logic       flush_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_byte_queue u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ser_rd(ser_rd), .ser_data(ser_data),
        .abort(abort), .lp_flush(lp_flush), .flush_clr(flush_clr),
        .full(full), .empty(empty), .flush_flag(flush_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given inputs, then return them to idle
    task automatic cyc(input bit wr, input logic [7:0] d, input bit rd,
                       input bit ab, input bit lp, input bit fc);
        cpu_wr = wr; cpu_wdata = d; ser_rd = rd;
        abort = ab; lp_flush = lp; flush_clr = fc;
        @(negedge clk);
        cpu_wr = 1'b0; ser_rd = 1'b0; abort = 1'b0; lp_flush = 1'b0; flush_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 empty", {7'd0, empty}, 8'd1);
        chk("R9 full", {7'd0, full}, 8'd0);
        chk("R9 flush", {7'd0, flush_flag}, 8'd1);
        chk("R3 peek after reset", cpu_rdata, 8'h00);
    endtask

    task automatic t_flush_clear;
        cyc(0, 8'h00, 0, 0, 0, 1);
        chk("R10 clear", {7'd0, flush_flag}, 8'd0);
    endtask

    task automatic t_small_burst;
        cyc(1, 8'hA0, 0, 0, 0, 0);
        chk("R6 write clears empty", {7'd0, empty}, 8'd0);
        cyc(1, 8'hA1, 0, 0, 0, 0);
        cyc(1, 8'hA2, 0, 0, 0, 0);
        chk("R3 peek at write slot", cpu_rdata, 8'h00);
        for (int i = 0; i < 3; i++) begin
            chk("R4 head byte", ser_data, 8'hA0 + 8'(i));
            cyc(0, 8'h00, 1, 0, 0, 0);
        end
        chk("R6 empty after drain", {7'd0, empty}, 8'd1);
        cyc(0, 8'h00, 1, 0, 0, 0);
        chk("R4 read while empty ignored", ser_data, 8'h00);
        chk("R4 still empty", {7'd0, empty}, 8'd1);
    endtask

    task automatic t_fill_wrap;
        for (int i = 0; i < 12; i++) begin
            if (i == 11) chk("R5 not full at 11", {7'd0, full}, 8'd0);
            cyc(1, 8'hB0 + 8'(i), 0, 0, 0, 0);
        end
        chk("R5 full at 12", {7'd0, full}, 8'd1);
        chk("R3 peek equals oldest when full", cpu_rdata, 8'hB0);
        cyc(1, 8'hFF, 0, 0, 0, 0);
        chk("R2 write while full ignored", cpu_rdata, 8'hB0);
        chk("R2 still full", {7'd0, full}, 8'd1);
        for (int i = 0; i < 12; i++) begin
            chk("R1 order across wrap", ser_data, 8'hB0 + 8'(i));
            cyc(0, 8'h00, 1, 0, 0, 0);
            if (i == 0) chk("R5 read clears full", {7'd0, full}, 8'd0);
        end
        chk("R6 empty after wrap drain", {7'd0, empty}, 8'd1);
    endtask

    task automatic t_simul;
        cyc(1, 8'hC0, 0, 0, 0, 0);
        cyc(1, 8'hC1, 1, 0, 0, 0);
        chk("R11 head advanced", ser_data, 8'hC1);
        chk("R11 not empty", {7'd0, empty}, 8'd0);
        chk("R11 not full", {7'd0, full}, 8'd0);
        cyc(0, 8'h00, 1, 0, 0, 0);
        chk("R11 drained", {7'd0, empty}, 8'd1);
    endtask

    task automatic t_abort;
        cyc(1, 8'hD0, 0, 0, 0, 0);
        cyc(1, 8'hD1, 0, 0, 0, 0);
        cyc(1, 8'h77, 1, 1, 0, 1);
        chk("R7 empty", {7'd0, empty}, 8'd1);
        chk("R7 full", {7'd0, full}, 8'd0);
        chk("R10 set beats clear", {7'd0, flush_flag}, 8'd1);
        cyc(1, 8'hE0, 0, 0, 0, 0);
        chk("R7 indices zeroed", ser_data, 8'hE0);
        cyc(0, 8'h00, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0);
        chk("R10 sticky", {7'd0, flush_flag}, 8'd1);
        cyc(0, 8'h00, 0, 0, 0, 1);
        chk("R10 cleared", {7'd0, flush_flag}, 8'd0);
    endtask

    task automatic t_lowpower;
        cyc(1, 8'hF0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 1, 0);
        chk("R8 empty", {7'd0, empty}, 8'd1);
        chk("R8 full", {7'd0, full}, 8'd0);
        chk("R8 flush", {7'd0, flush_flag}, 8'd1);
        cyc(1, 8'h5A, 0, 0, 0, 0);
        chk("R8 indices zeroed", ser_data, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_flush_clear;
        t_small_burst;
        t_fill_wrap;
        t_simul;
        t_abort;
        t_lowpower;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule